// File: doc/BRIEF.md
# Serial word transmit/receive queueing

This block sits between a software-visible register interface and a serial shift engine. It provides one queue per direction. Software writes words into the transmit queue, and the shift engine takes them from the head in order. The shift engine deposits each completed word into the receive queue, and software reads them from the head in order.

Each queue is a holding register with a RAM-style FIFO behind it. A queue therefore stores one word more than its FIFO depth. The holding register is the head of the queue: it is the word the engine sends next, or the word software reads next.

Status is given as two registered flags: free space on the transmit side and data present on the receive side. Words that cannot be stored are discarded and recorded in sticky error bits. A synchronous clear returns both queues to empty.

Top module: `serq_txrx`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `tx_not_full` is 1. At those times `rx_not_empty`, `eng_tx_valid`, `tx_overflow` and `rx_overrun` are 0.
- R2: The transmit queue holds `TX_DEPTH`+1 words. `tx_not_full` is high exactly when fewer words than that are stored. Its value changes on the clock edge that stores or removes a word.
- R3: A `tx_wr_en` pulse while `tx_not_full` is low is discarded, and `tx_overflow` goes to 1 on the following cycle. `tx_overflow` stays 1 until `clr` or `rst`. The discarded word never appears on `eng_tx_data`.
- R4: `eng_tx_valid` is high whenever the transmit queue holds a word. `eng_tx_data` then shows the oldest stored word. An `eng_tx_take` pulse while `eng_tx_valid` is high removes that word. Words leave in the order they were written.
- R5: An `eng_rx_done` pulse stores `eng_rx_data` as one received word. The receive queue holds `RX_DEPTH`+1 words. `rx_not_empty` is high exactly when at least one word is stored.
- R6: An `eng_rx_done` pulse while the receive queue is full is discarded, and `rx_overrun` goes to 1 on the following cycle. `rx_overrun` stays 1 until `clr` or `rst`. The stored words are unchanged.
- R7: `rx_rd_data` is valid while `rx_not_empty` is high and shows the oldest word. An `rx_rd_en` pulse removes that word. If more words are stored, the next one appears on the following cycle, so `rx_rd_en` held high streams one word per cycle. `rx_rd_en` while empty has no effect.
- R8: `clr` empties both queues and clears both sticky bits on the next edge. Any store or removal requested in the same cycle is ignored.
- R9: A store and a removal in the same cycle both take effect. The exceptions: a removal from an empty queue is ignored, and a store into a full queue is discarded even if a removal happens in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous clear of both queues and sticky bits |
| tx_wr_en | input | 1 | Software write strobe for the transmit queue |
| tx_wr_data | input | WORD_W | Word written by software |
| tx_not_full | output | 1 | Transmit queue has at least one free slot |
| tx_overflow | output | 1 | Sticky: a transmit write was discarded |
| eng_tx_valid | output | 1 | A transmit word is available to the engine |
| eng_tx_data | output | WORD_W | Oldest transmit word |
| eng_tx_take | input | 1 | Engine removes the oldest transmit word |
| eng_rx_done | input | 1 | Engine has completed one received word |
| eng_rx_data | input | WORD_W | Completed received word |
| rx_not_empty | output | 1 | Receive queue holds at least one word |
| rx_rd_data | output | WORD_W | Oldest received word |
| rx_rd_en | input | 1 | Software read strobe, removes the oldest received word |
| rx_overrun | output | 1 | Sticky: a received word was discarded |

## Verification
The bench builds the block with 8-bit words and a FIFO depth of 3 in each direction, so each queue holds four words. At that size every fill level from empty to two words past full is swept in both directions. It also covers a simultaneous store and removal at each occupancy from 0 to 4. That reaches the bypass load of an empty holding register, the refill from the FIFO with no bubble, and the full-queue discard together with a removal. Expected flags and data come from a software model of two bounded queues, checked on every cycle.

// File: rtl/sq_pkg.sv
package sq_pkg;
  // Bits needed to count 0..depth+1 stored words (FIFO plus holding register).
  function automatic int occ_bits(input int depth);
    return $clog2(depth + 2);
  endfunction

  // Bits needed to count 0..depth words in a FIFO.
  function automatic int fill_bits(input int depth);
    return $clog2(depth + 1);
  endfunction

  // Address bits for a FIFO memory, at least one.
  function automatic int addr_bits(input int depth);
    return (depth > 1) ? $clog2(depth) : 1;
  endfunction
endpackage

// File: rtl/sq_ram_fifo.sv
module sq_ram_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              clr,
  input  logic                              wr_en,
  input  logic [W-1:0]                      wr_data,
  input  logic                              rd_en,
  output logic [W-1:0]                      rd_q,
  output logic [sq_pkg::fill_bits(DEPTH)-1:0] fill
);
  localparam int AW = sq_pkg::addr_bits(DEPTH);
  localparam int FW = sq_pkg::fill_bits(DEPTH);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;

  // Write port and registered read port: block RAM friendly.
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= wr_data;
    if (rd_en) rd_q <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
    end else begin
      if (wr_en) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (rd_en) rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      fill <= fill + FW'(wr_en) - FW'(rd_en);
    end
  end

  // R2: the queue never writes into a full FIFO
  p_fifo_room_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !clr) |-> (fill < FW'(DEPTH)));
  // R7: the FIFO is only read while it holds data
  p_fifo_avail_r7: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !clr) |-> (fill != '0));
endmodule

// File: rtl/sq_hold_queue.sv
module sq_hold_queue #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic         head_valid,
  output logic [W-1:0] head_data,
  output logic         not_full,
  output logic         push_drop
);
  localparam int CAP = DEPTH + 1;
  localparam int OW  = sq_pkg::occ_bits(DEPTH);
  localparam int FW  = sq_pkg::fill_bits(DEPTH);

  logic [OW-1:0] occ, occ_nx;
  logic [FW-1:0] fifo_fill;
  logic [W-1:0]  fifo_q, byp_q;
  logic          head_from_fifo;
  logic          push_ok, pop_ok, fifo_empty, to_head, fifo_wr, fifo_rd;

  always_comb begin
    push_ok    = push && not_full && !clr;
    pop_ok     = pop && head_valid && !clr;
    fifo_empty = (fifo_fill == '0);
    // Word goes straight to the head when nothing older remains behind it.
    to_head    = push_ok && fifo_empty && (!head_valid || pop_ok);
    fifo_wr    = push_ok && !to_head;
    fifo_rd    = pop_ok && !fifo_empty;
    occ_nx     = occ + OW'(push_ok) - OW'(pop_ok);
    push_drop  = push && !not_full && !clr;
    head_data  = head_from_fifo ? fifo_q : byp_q;
  end

  sq_ram_fifo #(.W(W), .DEPTH(DEPTH)) u_fifo (
    .clk     (clk),
    .rst     (rst),
    .clr     (clr),
    .wr_en   (fifo_wr),
    .wr_data (push_data),
    .rd_en   (fifo_rd),
    .rd_q    (fifo_q),
    .fill    (fifo_fill)
  );

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      occ            <= '0;
      not_full       <= 1'b1;
      head_valid     <= 1'b0;
      head_from_fifo <= 1'b0;
    end else begin
      occ      <= occ_nx;
      not_full <= (occ_nx < OW'(CAP));
      if (to_head || fifo_rd) head_valid <= 1'b1;
      else if (pop_ok)        head_valid <= 1'b0;
      if (fifo_rd)      head_from_fifo <= 1'b1;
      else if (to_head) head_from_fifo <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (to_head) byp_q <= push_data;
  end

  // R2: the occupancy counter agrees with head plus FIFO contents
  p_occ_sum_r2: assert property (@(posedge clk) disable iff (rst)
    occ == (OW'(head_valid) + OW'(fifo_fill)));
  // R2: never more than depth plus one words
  p_cap_r2: assert property (@(posedge clk) disable iff (rst)
    occ <= OW'(CAP));
  // R4: the head is occupied whenever the queue is not empty
  p_head_when_occ_r4: assert property (@(posedge clk) disable iff (rst)
    (occ != '0) |-> head_valid);
  // R7: a pop with FIFO data behind it leaves the head filled on the next cycle
  p_refill_r7: assert property (@(posedge clk) disable iff (rst)
    (pop_ok && !fifo_empty) |=> head_valid);
endmodule

// File: rtl/serq_txrx.sv
module serq_txrx #(
  parameter int WORD_W   = 8,
  parameter int TX_DEPTH = 4,
  parameter int RX_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              tx_wr_en,
  input  logic [WORD_W-1:0] tx_wr_data,
  output logic              tx_not_full,
  output logic              tx_overflow,
  output logic              eng_tx_valid,
  output logic [WORD_W-1:0] eng_tx_data,
  input  logic              eng_tx_take,
  input  logic              eng_rx_done,
  input  logic [WORD_W-1:0] eng_rx_data,
  output logic              rx_not_empty,
  output logic [WORD_W-1:0] rx_rd_data,
  input  logic              rx_rd_en,
  output logic              rx_overrun
);
  logic tx_drop, rx_drop, rx_not_full;

  sq_hold_queue #(.W(WORD_W), .DEPTH(TX_DEPTH)) u_txq (
    .clk        (clk),
    .rst        (rst),
    .clr        (clr),
    .push       (tx_wr_en),
    .push_data  (tx_wr_data),
    .pop        (eng_tx_take),
    .head_valid (eng_tx_valid),
    .head_data  (eng_tx_data),
    .not_full   (tx_not_full),
    .push_drop  (tx_drop)
  );

  sq_hold_queue #(.W(WORD_W), .DEPTH(RX_DEPTH)) u_rxq (
    .clk        (clk),
    .rst        (rst),
    .clr        (clr),
    .push       (eng_rx_done),
    .push_data  (eng_rx_data),
    .pop        (rx_rd_en),
    .head_valid (rx_not_empty),
    .head_data  (rx_rd_data),
    .not_full   (rx_not_full),
    .push_drop  (rx_drop)
  );

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      tx_overflow <= 1'b0;
      rx_overrun  <= 1'b0;
    end else begin
      if (tx_drop) tx_overflow <= 1'b1;
      if (rx_drop) rx_overrun  <= 1'b1;
    end
  end

  // R3: a write while full raises the overflow bit
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    (tx_wr_en && !tx_not_full && !clr) |=> tx_overflow);
  // R3: overflow is sticky until clear
  p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (rst)
    (tx_overflow && !clr) |=> tx_overflow);
  // R6: an arrival into a full receive queue raises the overrun bit
  p_rx_overrun_r6: assert property (@(posedge clk) disable iff (rst)
    (eng_rx_done && !rx_not_full && !clr) |=> rx_overrun);
  // R6: overrun is sticky until clear
  p_ovr_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    (rx_overrun && !clr) |=> rx_overrun);
  // R8: clear leaves both queues empty and both error bits low
  p_clear_idle_r8: assert property (@(posedge clk) disable iff (rst)
    clr |=> (tx_not_full && !eng_tx_valid && !rx_not_empty && !tx_overflow && !rx_overrun));
endmodule

// File: tb/serq_txrx_test.sv
module serq_txrx_test;
  localparam int W   = 8;
  localparam int TXD = 3;
  localparam int RXD = 3;
  localparam int TXC = TXD + 1;
  localparam int RXC = RXD + 1;

  logic clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  logic         rst = 1'b1, clr = 1'b0;
  logic         tx_wr_en = 1'b0, eng_tx_take = 1'b0, eng_rx_done = 1'b0, rx_rd_en = 1'b0;
  logic [W-1:0] tx_wr_data = '0, eng_rx_data = '0;
  logic         tx_not_full, tx_overflow, eng_tx_valid, rx_not_empty, rx_overrun;
  logic [W-1:0] eng_tx_data, rx_rd_data;

  serq_txrx #(.WORD_W(W), .TX_DEPTH(TXD), .RX_DEPTH(RXD)) uut (
    .clk(clk), .rst(rst), .clr(clr),
    .tx_wr_en(tx_wr_en), .tx_wr_data(tx_wr_data),
    .tx_not_full(tx_not_full), .tx_overflow(tx_overflow),
    .eng_tx_valid(eng_tx_valid), .eng_tx_data(eng_tx_data), .eng_tx_take(eng_tx_take),
    .eng_rx_done(eng_rx_done), .eng_rx_data(eng_rx_data),
    .rx_not_empty(rx_not_empty), .rx_rd_data(rx_rd_data),
    .rx_rd_en(rx_rd_en), .rx_overrun(rx_overrun)
  );

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [W-1:0] mtx[$];
  logic [W-1:0] mrx[$];
  bit e_ovf = 0, e_ovr = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  task automatic verify(input string ctx);
    chk(tx_not_full == (mtx.size() < TXC), "R2", {ctx, " tx_not_full"}, tx_not_full, mtx.size() < TXC);
    chk(eng_tx_valid == (mtx.size() != 0), "R4", {ctx, " eng_tx_valid"}, eng_tx_valid, mtx.size() != 0);
    if (mtx.size() != 0)
      chk(eng_tx_data == mtx[0], "R4", {ctx, " eng_tx_data"}, eng_tx_data, mtx[0]);
    chk(tx_overflow == e_ovf, "R3", {ctx, " tx_overflow"}, tx_overflow, e_ovf);
    chk(rx_not_empty == (mrx.size() != 0), "R5", {ctx, " rx_not_empty"}, rx_not_empty, mrx.size() != 0);
    if (mrx.size() != 0)
      chk(rx_rd_data == mrx[0], "R7", {ctx, " rx_rd_data"}, rx_rd_data, mrx[0]);
    chk(rx_overrun == e_ovr, "R6", {ctx, " rx_overrun"}, rx_overrun, e_ovr);
  endtask

  // One clock cycle of stimulus, model update, and check after the edge.
  task automatic cyc(input bit wr, input logic [W-1:0] wd, input bit take,
                     input bit done, input logic [W-1:0] rd_d, input bit rd,
                     input bit c, input string ctx);
    tx_wr_en = wr; tx_wr_data = wd; eng_tx_take = take;
    eng_rx_done = done; eng_rx_data = rd_d; rx_rd_en = rd; clr = c;
    if (c) begin
      mtx.delete(); mrx.delete(); e_ovf = 0; e_ovr = 0;
    end else begin
      bit tpop = take && (mtx.size() > 0);
      bit tacc = wr && (mtx.size() < TXC);
      bit rpop = rd && (mrx.size() > 0);
      bit racc = done && (mrx.size() < RXC);
      if (wr && !tacc) e_ovf = 1;
      if (done && !racc) e_ovr = 1;
      if (tpop) void'(mtx.pop_front());
      if (tacc) mtx.push_back(wd);
      if (rpop) void'(mrx.pop_front());
      if (racc) mrx.push_back(rd_d);
    end
    tick;
    tx_wr_en = 0; eng_tx_take = 0; eng_rx_done = 0; rx_rd_en = 0; clr = 0;
    verify(ctx);
  endtask

  task automatic summary;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL R1 watchdog actual running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    // R1: reset state
    tick; tick;
    chk(tx_not_full == 1, "R1", "reset tx_not_full", tx_not_full, 1);
    chk(eng_tx_valid == 0, "R1", "reset eng_tx_valid", eng_tx_valid, 0);
    chk(rx_not_empty == 0, "R1", "reset rx_not_empty", rx_not_empty, 0);
    chk(tx_overflow == 0, "R1", "reset tx_overflow", tx_overflow, 0);
    chk(rx_overrun == 0, "R1", "reset rx_overrun", rx_overrun, 0);
    rst = 0;
    tick;
    verify("R1 after reset");

    // R2 R3 R4: transmit fill levels 0..CAP+2, then stream out
    for (int n = 0; n <= TXC + 2; n++) begin
      for (int i = 0; i < n; i++) cyc(1, W'(n * 16 + i), 0, 0, '0, 0, 0, "R2 tx fill");
      for (int i = 0; i < TXC + 1; i++) cyc(0, '0, 1, 0, '0, 0, 0, "R4 tx drain");
      cyc(0, '0, 0, 0, '0, 0, 1, "R8 clear");
    end

    // R5 R6 R7: receive fill levels 0..CAP+2, then read every cycle
    for (int n = 0; n <= RXC + 2; n++) begin
      for (int i = 0; i < n; i++) cyc(0, '0, 0, 1, W'(128 + n * 16 + i), 0, 0, "R5 rx fill");
      for (int i = 0; i < RXC + 1; i++) cyc(0, '0, 0, 0, '0, 1, 0, "R7 rx stream");
      cyc(0, '0, 0, 0, '0, 0, 1, "R8 clear");
    end

    // R9: simultaneous store and removal at every occupancy
    for (int k = 0; k <= TXC; k++) begin
      for (int i = 0; i < k; i++) cyc(1, W'(i + 1), 0, 1, W'(64 + i), 0, 0, "R9 prefill");
      cyc(1, W'(8'hA0 + k), 1, 1, W'(8'hC0 + k), 1, 0, "R9 both");
      for (int i = 0; i < TXC + 1; i++) cyc(0, '0, 1, 0, '0, 1, 0, "R9 drain");
      cyc(0, '0, 0, 0, '0, 0, 1, "R8 clear");
    end

    // Mixed traffic: writes every cycle, removals every other cycle
    for (int i = 0; i < 24; i++)
      cyc(1, W'(i * 7), i[0], 1, W'(i * 5 + 3), i[0], 0, "R9 mixed");

    // R8: clear while full with traffic in the same cycle
    cyc(1, 8'h11, 1, 1, 8'h22, 1, 1, "R8 clear with traffic");
    cyc(0, '0, 0, 0, '0, 0, 0, "R8 idle after clear");
    cyc(1, 8'h5A, 0, 1, 8'hA5, 0, 0, "R8 usable after clear");
    cyc(0, '0, 1, 0, '0, 1, 0, "R8 drain after clear");

    finished = 1;
    summary();
    $finish;
  end
endmodule